// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a simple single-beat valid/ready request port and an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. It accepts one read or one write at a time. For each request it produces registered, active-low chip-select, write-strobe and output-enable signals, and it holds address and data steady for the whole access. The data bus is presented as a separate output value, output-enable and input value, so the pad ring can build the tri-state pin.

Every phase length comes from a nanosecond limit divided by the clock period parameter and rounded up. A read holds chip select and output enable low long enough to meet the slowest of the address, chip-select and output-enable access times. The read data is sampled on the last clock of that phase and returned with a one-cycle valid pulse. After the read, the bus is left quiet long enough for the memory to release its drivers. A write first lowers chip select and drives data. It then pulses the write strobe low for a fixed window. The write strobe always rises before chip select, so the write ends on the write strobe and the shorter hold and recovery limits apply.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After synchronous reset, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0, rdata_valid is 0 and req_ready is 1.
- R2: A read holds sram_ce_n and sram_oe_n low, with sram_we_n high, for exactly 7 clocks at 10 ns. This is the ceiling of the largest of 70 ns address access, 70 ns chip-select access, 35 ns output-enable access and 70 ns read cycle.
- R3: Read data is sampled from sram_dq_in on the final clock of the read access phase. rdata_valid is a single-cycle pulse that is first high in the 8th cycle after the accepting clock edge, and rdata then holds the sampled byte.
- R4: After a read, all strobes stay high for at least 3 clocks (ceiling of 25 ns release time) before any new access. req_ready is low for 10 cycles after a read is accepted.
- R5: A write lowers sram_ce_n exactly one clock before sram_we_n falls. sram_we_n stays low for exactly 6 clocks, the ceiling of the largest of the 55 ns strobe width and 30 ns data setup.
- R6: A write ends with sram_we_n rising while sram_ce_n is still low. sram_ce_n rises exactly one clock later, and sram_dq_oe is still 1 in that hold clock.
- R7: sram_oe_n is high whenever sram_we_n is low. sram_dq_oe is 1 only while sram_ce_n is low in a write, and never while sram_oe_n is low.
- R8: After a write, all strobes stay high for at least 1 clock (ceiling of 5 ns recovery). req_ready is low for 9 cycles after a write is accepted.
- R9: sram_addr does not change on any clock in which sram_ce_n stays low.
- R10: A request is taken only when req_ready is 1. A request held valid during a busy period is taken on the first clock edge at which the controller is idle, and it is executed exactly once.
- R11: The byte written to an address is returned by a later read of that address. This holds at address 0, at the top address 0x7FFFF, and after an overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| rdata | output | 8 | Last read byte |
| rdata_valid | output | 1 | One-cycle pulse, rdata updated |
| sram_addr | output | 19 | Address to the memory |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 8 | Data read from the memory pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
A phase counter that is loaded with the wrong length appears at the strobe pins in the same access: the low window of the write strobe or the output enable is too short or too long. A read that is too short returns the memory model's not-yet-valid filler byte instead of the stored value. A state register that skips or reorders phases shows up within a clock or two as a write strobe without chip select, as data being driven during output enable, or as chip select rising before the write strobe. A lost request handshake leaves req_ready at a wrong busy length, or leaves a stored byte unreadable on the next read.

// File: rtl/srctl_pkg.sv
// Shared types and helpers for the SRAM strobe controller.
// Assumes all timing limits are given in whole nanoseconds.
package srctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5,
        ST_WR_REC   = 3'd6
    } srctl_state_e;

    // Round a nanosecond limit up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/srctl_timer.sv
// Phase length down-counter.
// Loaded with (length - 1) on entry to a phase; done is high in the last
// cycle of the phase. Assumes load values fit in CNT_W bits.
module srctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // A running count only leaves zero through a load (phase entry).
    p_zero_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/srctl_fsm.sv
// Access sequencer: walks read and write phases and produces registered,
// glitch-free active-low strobes plus the data drive enable.
// Assumes every phase length parameter is at least 1.
module srctl_fsm
    import srctl_pkg::*;
#(
    parameter int unsigned N_RD  = 7,
    parameter int unsigned N_OD  = 3,
    parameter int unsigned N_WSU = 1,
    parameter int unsigned N_WP  = 6,
    parameter int unsigned N_WH  = 1,
    parameter int unsigned N_REC = 1,
    parameter int          CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);
    srctl_state_e state_q, state_d;
    logic ce_d, we_d, oe_d, dqoe_d;

    // Next-state selection and phase length loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    state_d = ST_WR_SETUP;
                    tmr_val = CNT_W'(N_WSU - 1);
                end else begin
                    state_d = ST_RD_ACC;
                    tmr_val = CNT_W'(N_RD - 1);
                end
            end
            ST_RD_ACC: if (tmr_done) begin
                capture  = 1'b1;
                state_d  = ST_RD_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_OD - 1);
            end
            ST_RD_TURN: if (tmr_done) state_d = ST_IDLE;
            ST_WR_SETUP: if (tmr_done) begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_WP - 1);
            end
            ST_WR_PULSE: if (tmr_done) begin
                state_d  = ST_WR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_WH - 1);
            end
            ST_WR_HOLD: if (tmr_done) begin
                state_d  = ST_WR_REC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_REC - 1);
            end
            ST_WR_REC: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe levels decoded from the state being entered.
    always_comb begin
        ce_d   = !(state_d inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
        we_d   = (state_d != ST_WR_PULSE);
        oe_d   = (state_d != ST_RD_ACC);
        dqoe_d = (state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
    end

    // State and strobe registers, all strobes inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dq_oe   <= 1'b0;
        end else begin
            state_q <= state_d;
            ce_n    <= ce_d;
            we_n    <= we_d;
            oe_n    <= oe_d;
            dq_oe   <= dqoe_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !ce_n));
    p_we_ends_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n);
    p_ce_follows_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |=> ce_n);
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/srctl_datapath.sv
// Address/data holding registers and read-data capture.
// Assumes accept only occurs while the sequencer is idle.
module srctl_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] sram_dq_in,
    input  logic              ce_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    // Latch address and write byte when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
        end
    end

    // Sample the memory on the last access clock and flag it one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            if (capture) rdata <= sram_dq_in;
            rdata_valid <= capture;
        end
    end

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(sram_addr));
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top level: converts valid/ready single-beat requests into asynchronous
// SRAM strobes. Phase lengths are derived from ns limits and CLK_NS.
// Assumes sram_dq_in is stable around the capture edge (pad-synchronous).
module sram_strobe_ctrl
    import srctl_pkg::*;
#(
    parameter int unsigned CLK_NS   = 10,
    parameter int          ADDR_W   = 19,
    parameter int          DATA_W   = 8,
    parameter int unsigned T_ACC_NS = 70,
    parameter int unsigned T_CO_NS  = 70,
    parameter int unsigned T_OE_NS  = 35,
    parameter int unsigned T_RC_NS  = 70,
    parameter int unsigned T_OD_NS  = 25,
    parameter int unsigned T_WP_NS  = 55,
    parameter int unsigned T_DS_NS  = 30,
    parameter int unsigned T_WR_NS  = 5,
    parameter int unsigned T_WC_NS  = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    localparam int unsigned N_RD  = max3(ns_to_cyc(T_ACC_NS, CLK_NS),
                                         max3(ns_to_cyc(T_CO_NS, CLK_NS),
                                              ns_to_cyc(T_OE_NS, CLK_NS), 1),
                                         ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int unsigned N_OD  = ns_to_cyc(T_OD_NS, CLK_NS);
    localparam int unsigned N_WSU = 1;
    localparam int unsigned N_WH  = 1;
    localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned N_WCP = (N_WC > N_WSU + N_WH) ? N_WC - N_WSU - N_WH : 1;
    localparam int unsigned N_WP  = max3(ns_to_cyc(T_WP_NS, CLK_NS),
                                         ns_to_cyc(T_DS_NS, CLK_NS), N_WCP);
    localparam int unsigned N_REC = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int unsigned N_MAX = max3(max3(N_RD, N_OD, N_WP), N_REC, 2);
    localparam int          CNT_W = $clog2(N_MAX + 1);

    logic             accept, capture, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    srctl_fsm #(
        .N_RD(N_RD), .N_OD(N_OD), .N_WSU(N_WSU), .N_WP(N_WP),
        .N_WH(N_WH), .N_REC(N_REC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .tmr_done(tmr_done), .req_ready(req_ready),
        .accept(accept), .capture(capture),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
        .dq_oe(sram_dq_oe)
    );

    srctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    srctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
        .capture(capture), .sram_dq_in(sram_dq_in), .ce_n(sram_ce_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    p_ready_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));
endmodule

// File: tb/sim_sram_strobe_ctrl.sv
// Directed bench: behavioural SRAM model with access-time filler, strobe
// monitors, and one task per scenario.
module sim_sram_strobe_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rdata_valid, sram_dq_oe;
    logic [7:0]  rdata, sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] mem    [int];
    logic [7:0] golden [int];

    sram_strobe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory model: data valid only once 70 ns of read strobe have elapsed.
    int rd_cnt = 0;
    always @(posedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_cnt = rd_cnt + 1;
        else rd_cnt = 0;
        if (rd_cnt >= 6)
            sram_dq_in <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
        else
            sram_dq_in <= 8'hEE;
    end

    // Strobe monitors.
    logic prev_we = 1'b1, prev2_we = 1'b1, prev_ce = 1'b1, prev_oe = 1'b1;
    logic [18:0] prev_addr = '0;
    int we_len = 0, oe_len = 0, ce_low_len = 0, ce_hi_len = 0;
    bit in_write = 0, last_write = 0, seen_acc = 0;
    int viol_r7 = 0, viol_r9 = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (!sram_we_n && prev_we)
                check(ce_low_len == 1, "R5", "CE lead before WE", ce_low_len, 1);
            if (sram_we_n && !prev_we) begin
                check(we_len == 6, "R5", "WE low clocks", we_len, 6);
                check(!sram_ce_n, "R6", "CE low at WE rise", sram_ce_n, 0);
                check(sram_dq_oe, "R6", "data driven in hold", sram_dq_oe, 1);
            end
            if (sram_oe_n && !prev_oe)
                check(oe_len == 7, "R2", "OE low clocks", oe_len, 7);
            if (sram_ce_n && !prev_ce && in_write)
                check(prev_we && !prev2_we, "R6", "CE rise one clock after WE",
                      int'(prev2_we), 0);
            if (!sram_ce_n && prev_ce && seen_acc) begin
                if (last_write)
                    check(ce_hi_len >= 1, "R8", "gap after write", ce_hi_len, 1);
                else
                    check(ce_hi_len >= 3, "R4", "gap after read", ce_hi_len, 3);
            end
            if (!sram_we_n && !sram_oe_n) viol_r7++;
            if (sram_dq_oe && (!sram_oe_n || sram_ce_n)) viol_r7++;
            if (!sram_oe_n && !sram_we_n) viol_r7++;
            if (!sram_ce_n && !prev_ce && sram_addr != prev_addr) viol_r9++;
            // write commit on WE rise, as a real part latches it
            if (sram_we_n && !prev_we && !sram_ce_n) mem[int'(sram_addr)] = sram_dq_out;
            // counter updates
            we_len     = sram_we_n ? 0 : we_len + 1;
            oe_len     = sram_oe_n ? 0 : oe_len + 1;
            ce_low_len = sram_ce_n ? 0 : ce_low_len + 1;
            ce_hi_len  = sram_ce_n ? ce_hi_len + 1 : 0;
            if (!sram_we_n) in_write = 1;
            if (sram_ce_n && !prev_ce) begin
                last_write = in_write;
                in_write = 0;
                seen_acc = 1;
                ce_hi_len = 1;
            end
            prev2_we = prev_we;
            prev_we = sram_we_n;
            prev_ce = sram_ce_n;
            prev_oe = sram_oe_n;
            prev_addr = sram_addr;
        end
    end

    // Issue a request at a negedge; returns after the accepting posedge.
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        check(req_ready, "R10", "ready when idle", req_ready, 1);
        @(posedge clk);
    endtask

    task automatic write_tail(input string tag);
        int busy = 0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 40) begin
            busy++;
            @(negedge clk);
        end
        check(busy == 9, "R8", {"write busy ", tag}, busy, 9);
    endtask

    task automatic read_tail(input logic [7:0] exp, input string tag);
        int idx = 0, lat = 0, pulses = 0;
        logic [7:0] got = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && idx < 40) begin
            idx++;
            if (rdata_valid) begin
                pulses++;
                if (lat == 0) begin lat = idx; got = rdata; end
            end
            @(negedge clk);
        end
        check(lat == 8, "R3", {"read latency ", tag}, lat, 8);
        check(pulses == 1, "R3", {"valid pulses ", tag}, pulses, 1);
        check(got == exp, "R11", {"read data ", tag}, got, exp);
        check(idx == 10, "R4", {"read busy ", tag}, idx, 10);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        golden[int'(a)] = d;
        write_tail($sformatf("@%0h", a));
    endtask

    task automatic do_read(input logic [18:0] a);
        logic [7:0] e;
        e = golden.exists(int'(a)) ? golden[int'(a)] : 8'h00;
        issue(1'b0, a, 8'h00);
        read_tail(e, $sformatf("@%0h", a));
    endtask

    // R1: reset state at the ports.
    task automatic test_reset;
        @(negedge clk);
        check(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes high",
              {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        check(!sram_dq_oe, "R1", "no drive", sram_dq_oe, 0);
        check(!rdata_valid, "R1", "no valid", rdata_valid, 0);
        check(req_ready, "R1", "ready", req_ready, 1);
    endtask

    // R11: data patterns at the address extremes.
    task automatic test_patterns;
        do_write(19'h00000, 8'hA5);
        do_write(19'h7FFFF, 8'h5A);
        do_write(19'h2AAAA, 8'hFF);
        do_write(19'h55555, 8'h00);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_read(19'h2AAAA);
        do_read(19'h55555);
        do_read(19'h12345);
    endtask

    // R11: overwrite then read back; read-to-read and write-to-write.
    task automatic test_overwrite;
        do_write(19'h2AAAA, 8'h3C);
        do_write(19'h2AAAA, 8'hC3);
        do_read(19'h2AAAA);
        do_read(19'h2AAAA);
    endtask

    // R10: a read held valid through a write busy period is taken once.
    task automatic test_pending;
        int waitc = 0;
        issue(1'b1, 19'h01234, 8'h96);
        golden[32'h01234] = 8'h96;
        @(negedge clk);
        req_write = 1'b0; req_addr = 19'h01234; req_wdata = 8'h00;
        while (!req_ready && waitc < 40) begin
            waitc++;
            @(negedge clk);
        end
        check(waitc == 9, "R10", "pending wait", waitc, 9);
        @(posedge clk);
        read_tail(8'h96, "pending");
        repeat (4) @(negedge clk);
        check(!rdata_valid && req_ready, "R10", "executed once", rdata_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_patterns();
        test_overwrite();
        test_pending();
        repeat (5) @(negedge clk);
        check(viol_r7 == 0, "R7", "OE/drive overlap cycles", viol_r7, 0);
        check(viol_r9 == 0, "R9", "address change under CE", viol_r9, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule